// File: doc/BRIEF.md
# Scalar FP64 Compare Unit

This unit compares two IEEE-754 double-precision numbers held in the low 64 bits of two 128-bit source operands. An 8-bit immediate selects the relation to test. The result is one bit, true or false, and a mode input chooses how it is presented.

- **Legacy mode** writes an all-ones or all-zeros low quadword and keeps the high quadword of the old destination.
- **Three-operand mode** writes the same low quadword and takes the high quadword from source 1.
- **Mask mode** produces a single bit at position 0 of a mask word, gated by a writemask bit.

The compare logic is combinational. An optional output register, selected by a parameter and enabled by default, captures both results when `in_valid` is high. A matching `out_valid` follows one cycle later.

Top module: `fp64_scalar_cmp`

## Requirements
- R1: Only bits 63:0 of `src1` and of `src2` decide the comparison outcome. The relation tested is `src1[63:0] <op> src2[63:0]`; for example, code 1 is true when src1 is less than src2.
- R2: When `mode` is 2'b00 (legacy), the relation code is `{2'b00, imm[2:0]}`, and `imm[7:3]` has no effect on either output.
- R3: When `mode` is 2'b01 (three-operand) or 2'b1x (mask), the relation code is `imm[4:0]`. `imm[7:5]` has no effect, and codes 16..31 behave like codes 0..15.
- R4: Codes 0..7 mean, in order: equal, less, less-or-equal, unordered, not-equal, not-less, not-less-or-equal, ordered. Codes 0, 1 and 2 are false when either operand is a NaN. Codes 4, 5 and 6 are true when either operand is a NaN.
- R5: Codes 8..15 mean, in order:
  - 8: equal-or-unordered
  - 9: not-greater-or-equal, true when unordered
  - 10: not-greater, true when unordered
  - 11: always false
  - 12: ordered and not equal
  - 13: greater-or-equal
  - 14: greater
  - 15: always true

  Codes 13 and 14 are false when unordered.
- R6: A value is a NaN when its exponent bits 62:52 are all ones and its mantissa bits 51:0 are nonzero. +0.0 and -0.0 compare as equal. Infinities and subnormals order by value.
- R7: In legacy mode, `vec_res[63:0]` is all ones when the relation is true and all zeros when it is false. `vec_res[127:64]` equals `dst_old[127:64]`, and `mask_res` is zero.
- R8: In three-operand mode, `vec_res[63:0]` is the all-ones or all-zeros mask. `vec_res[127:64]` equals `src1[127:64]`, and `mask_res` is zero.
- R9: In mask mode, `mask_res[0]` is the relation result ANDed with `wmask`. `mask_res[63:1]` is zero, and `vec_res` is zero.
- R10: With the output register enabled, results and `out_valid` appear one clock after a cycle with `in_valid` high. When `in_valid` is low, `out_valid` drops and the result outputs hold. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Inputs valid; output register loads |
| src1 | input | 128 | First source; low half compared, high half used in three-operand mode |
| src2 | input | 128 | Second source; low half compared |
| dst_old | input | 128 | Previous destination contents for legacy merge |
| imm | input | 8 | Relation selector immediate |
| mode | input | 2 | 00 legacy, 01 three-operand, 1x mask |
| wmask | input | 1 | Writemask bit for mask mode |
| out_valid | output | 1 | Results valid |
| vec_res | output | 128 | Vector-format result |
| mask_res | output | 64 | Mask-format result |

## Verification
The assertions assume the output register is enabled. They also assume every input is at a known level whenever `in_valid` is high, because the properties sample the inputs in that cycle. The bench drives all inputs on the falling edge and keeps them defined for the whole run. It fills the unused upper operand bits and the ignored immediate bits with pseudo-random data, so any leak into the result shows up at the ports. The operand set covers signed zeros, infinities, a subnormal, a quiet NaN and a signalling NaN, and it is swept against all 32 relation codes in every mode.

// File: rtl/fp64_scalar_cmp.sv
module fp64_scalar_cmp #(
  parameter int VW      = 128,
  parameter int FW      = 64,
  parameter int EW      = 11,
  parameter int MASKW   = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VW-1:0]    src1,
  input  logic [VW-1:0]    src2,
  input  logic [VW-1:0]    dst_old,
  input  logic [7:0]       imm,
  input  logic [1:0]       mode,
  input  logic             wmask,
  output logic             out_valid,
  output logic [VW-1:0]    vec_res,
  output logic [MASKW-1:0] mask_res
);
  localparam int MW = FW - EW - 1;
  localparam logic [1:0] M_LEG = 2'b00;
  localparam logic [1:0] M_VEX = 2'b01;

  logic [FW-1:0] a, b;
  logic a_nan, b_nan, unord, both_zero, eq_raw, lt_raw;
  logic eq, lt, gt, res;
  logic [4:0] code;

  assign a = src1[FW-1:0];
  assign b = src2[FW-1:0];

  assign a_nan = (&a[FW-2:MW]) & (|a[MW-1:0]);
  assign b_nan = (&b[FW-2:MW]) & (|b[MW-1:0]);
  assign unord = a_nan | b_nan;

  assign both_zero = ~|a[FW-2:0] & ~|b[FW-2:0];
  assign eq_raw    = (a == b) | both_zero;

  always_comb begin
    if (both_zero)                 lt_raw = 1'b0;
    else if (a[FW-1] != b[FW-1])   lt_raw = a[FW-1];
    else if (!a[FW-1])             lt_raw = a[FW-2:0] < b[FW-2:0];
    else                           lt_raw = a[FW-2:0] > b[FW-2:0];
  end

  assign eq = ~unord & eq_raw;
  assign lt = ~unord & lt_raw;
  assign gt = ~unord & ~eq_raw & ~lt_raw;

  assign code = (mode == M_LEG) ? {2'b00, imm[2:0]} : imm[4:0];

  always_comb begin
    case (code[3:0])
      4'd0:    res = eq;
      4'd1:    res = lt;
      4'd2:    res = lt | eq;
      4'd3:    res = unord;
      4'd4:    res = ~eq;
      4'd5:    res = ~lt;
      4'd6:    res = ~(lt | eq);
      4'd7:    res = ~unord;
      4'd8:    res = eq | unord;
      4'd9:    res = lt | unord;
      4'd10:   res = lt | eq | unord;
      4'd11:   res = 1'b0;
      4'd12:   res = lt | gt;
      4'd13:   res = gt | eq;
      4'd14:   res = gt;
      default: res = 1'b1;
    endcase
  end

  logic [VW-1:0]    vec_c;
  logic [MASKW-1:0] mask_c;

  always_comb begin
    vec_c  = '0;
    mask_c = '0;
    if (mode == M_LEG)      vec_c = {dst_old[VW-1:FW], {FW{res}}};
    else if (mode == M_VEX) vec_c = {src1[VW-1:FW], {FW{res}}};
    else                    mask_c[0] = res & wmask;
  end

  logic unused_bits;
  assign unused_bits = ^{src2[VW-1:FW], imm[7:5], code[4]};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          vec_res   <= '0;
          mask_res  <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            vec_res  <= vec_c;
            mask_res <= mask_c;
          end
        end
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign out_valid  = in_valid;
      assign vec_res    = vec_c;
      assign mask_res   = mask_c;
    end
  endgenerate
endmodule

// File: rtl/fp64_scalar_cmp_chk.sv
module fp64_scalar_cmp_chk #(
  parameter int VW      = 128,
  parameter int FW      = 64,
  parameter int MASKW   = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [VW-1:0]    src1,
  input logic [VW-1:0]    src2,
  input logic [VW-1:0]    dst_old,
  input logic [7:0]       imm,
  input logic [1:0]       mode,
  input logic             wmask,
  input logic             out_valid,
  input logic [VW-1:0]    vec_res,
  input logic [MASKW-1:0] mask_res
);
  logic any_nan;
  assign any_nan = ((&src1[62:52]) & (|src1[51:0])) | ((&src2[62:52]) & (|src2[51:0]));

  logic unused_chk;
  assign unused_chk = ^{src2[VW-1:FW], dst_old[FW-1:0], imm[7:5]};

  generate
    if (REG_OUT) begin : g_props
      p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(vec_res) && $stable(mask_res)));
      p_legacy_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b00) |=> (vec_res[VW-1:FW] == $past(dst_old[VW-1:FW]) && mask_res == '0));
      p_vex_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b01) |=> (vec_res[VW-1:FW] == $past(src1[VW-1:FW]) && mask_res == '0));
      p_mask_fmt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1]) |=> (vec_res == '0 && $countones(mask_res) <= 1 && (mask_res[0] -> $past(wmask))));
      p_unord_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b01 && imm[3:0] == 4'd3 && any_nan) |=> (&vec_res[FW-1:0]));
      p_low_uniform_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mode[1]) |-> (vec_res[FW-1:0] == '0 || (&vec_res[FW-1:0])));
    end
  endgenerate
endmodule

bind fp64_scalar_cmp fp64_scalar_cmp_chk #(
  .VW(VW), .FW(FW), .MASKW(MASKW), .REG_OUT(REG_OUT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src1(src1), .src2(src2),
  .dst_old(dst_old), .imm(imm), .mode(mode), .wmask(wmask),
  .out_valid(out_valid), .vec_res(vec_res), .mask_res(mask_res)
);

// File: tb/fp64_scalar_cmp_tb_top.sv
module fp64_scalar_cmp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [127:0] src1 = '0, src2 = '0, dst_old = '0;
  logic [7:0] imm = '0;
  logic [1:0] mode = '0;
  logic wmask = 1'b0;
  logic out_valid;
  logic [127:0] vec_res;
  logic [63:0] mask_res;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  fp64_scalar_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src1(src1), .src2(src2),
    .dst_old(dst_old), .imm(imm), .mode(mode), .wmask(wmask),
    .out_valid(out_valid), .vec_res(vec_res), .mask_res(mask_res)
  );

  typedef struct {
    logic [127:0] vec;
    logic [63:0]  msk;
    string        tag;
  } exp_t;

  exp_t sb[$];
  logic [127:0] last_vec = '0;
  logic [63:0]  last_msk = '0;

  logic [63:0] vals [10] = '{
    64'h3FF0000000000000, 64'h4000000000000000, 64'hBFF0000000000000,
    64'h0000000000000000, 64'h8000000000000000, 64'h7FF8000000000000,
    64'h7FF0000000000000, 64'hFFF0000000000000, 64'h0000000000000001,
    64'h7FF0000000000001
  };

  function automatic bit is_nan(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  function automatic bit ref_rel(logic [3:0] c, logic [63:0] x, logic [63:0] y);
    real ra, rb;
    bit un;
    ra = $bitstoreal(x);
    rb = $bitstoreal(y);
    un = is_nan(x) || is_nan(y);
    case (c)
      4'd0:  return !un && (ra == rb);
      4'd1:  return !un && (ra < rb);
      4'd2:  return !un && (ra <= rb);
      4'd3:  return un;
      4'd4:  return un || !(ra == rb);
      4'd5:  return un || !(ra < rb);
      4'd6:  return un || !(ra <= rb);
      4'd7:  return !un;
      4'd8:  return un || (ra == rb);
      4'd9:  return un || !(ra >= rb);
      4'd10: return un || !(ra > rb);
      4'd11: return 1'b0;
      4'd12: return !un && ((ra < rb) || (ra > rb));
      4'd13: return !un && (ra >= rb);
      4'd14: return !un && (ra > rb);
      default: return 1'b1;
    endcase
  endfunction

  task automatic drive(logic [63:0] x, logic [63:0] y, logic [7:0] im,
                       logic [1:0] md, logic wm, string tag);
    exp_t e;
    logic [3:0] c;
    bit r;
    @(negedge clk);
    src1     = {$urandom, $urandom, x};
    src2     = {$urandom, $urandom, y};
    dst_old  = {$urandom, $urandom, $urandom, $urandom};
    imm      = im;
    mode     = md;
    wmask    = wm;
    in_valid = 1'b1;
    c = (md == 2'b00) ? {1'b0, im[2:0]} : im[3:0];
    r = ref_rel(c, x, y);
    e.tag = tag;
    e.msk = '0;
    if (md == 2'b00)      e.vec = {dst_old[127:64], {64{r}}};
    else if (md == 2'b01) e.vec = {src1[127:64], {64{r}}};
    else begin
      e.vec = '0;
      e.msk = {63'b0, r & wm};
    end
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R10: out_valid with no pending item, actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (vec_res !== e.vec || mask_res !== e.msk) begin
          errors++;
          $display("FAIL %s: actual vec=%h msk=%h expected vec=%h msk=%h",
                   e.tag, vec_res, mask_res, e.vec, e.msk);
        end
      end
      last_vec = vec_res;
      last_msk = mask_res;
    end
  end

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || vec_res !== '0 || mask_res !== '0) begin
      errors++;
      $display("FAIL R10 reset: actual v=%b vec=%h msk=%h expected all zero",
               out_valid, vec_res, mask_res);
    end
    rst_n = 1'b1;

    // R6: signed zeros equal, NaN detection; R1: direction src1 < src2
    drive(64'h0000000000000000, 64'h8000000000000000, 8'd0, 2'b01, 1'b1, "R6 +0==-0");
    drive(64'h3FF0000000000000, 64'h4000000000000000, 8'd1, 2'b01, 1'b1, "R1 1<2");
    drive(64'h4000000000000000, 64'h3FF0000000000000, 8'd1, 2'b01, 1'b1, "R1 2<1");
    drive(64'h7FF0000000000001, 64'h3FF0000000000000, 8'd3, 2'b00, 1'b1, "R6 snan unord");
    drive(64'h7FF0000000000000, 64'h7FF0000000000000, 8'd3, 2'b00, 1'b1, "R6 inf ordered");
    // R2: legacy ignores imm[7:3]
    drive(64'h3FF0000000000000, 64'h4000000000000000, 8'hF9, 2'b00, 1'b1, "R2 ignored bits");
    drive(64'h3FF0000000000000, 64'h3FF0000000000000, 8'h08, 2'b00, 1'b1, "R2 code8 as 0");
    // R3: upper imm bits ignored, codes 16..31 alias
    drive(64'h3FF0000000000000, 64'h4000000000000000, 8'hEE, 2'b01, 1'b1, "R3 alias 14");
    drive(64'h3FF0000000000000, 64'h4000000000000000, 8'h1B, 2'b10, 1'b1, "R3 alias 11");
    // R9: writemask gating
    drive(64'h3FF0000000000000, 64'h3FF0000000000000, 8'd15, 2'b10, 1'b0, "R9 wmask off");
    drive(64'h3FF0000000000000, 64'h3FF0000000000000, 8'd15, 2'b11, 1'b1, "R9 wmask on");

    // Full sweep: R4 R5 R7 R8 R9
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 32; c++)
        for (int i = 0; i < 10; i++)
          for (int j = 0; j < 10; j++) begin
            logic [7:0] im;
            im = {$urandom} % 256;
            im[4:0] = c[4:0];
            drive(vals[i], vals[j], im, m[1:0], j[0],
                  m == 0 ? "R7 legacy sweep" : m == 1 ? "R8 vex sweep" :
                  (c % 16 < 8) ? "R4 R9 mask sweep" : "R5 R9 mask sweep");
          end

    // R10: hold while idle
    idle(4);
    checks++;
    if (vec_res !== last_vec || mask_res !== last_msk || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 hold: actual vec=%h msk=%h v=%b expected vec=%h msk=%h v=0",
               vec_res, mask_res, out_valid, last_vec, last_msk);
    end
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10 pending: actual=%0d expected=0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule